// File: doc/BRIEF.md
# Critical-Word-First Cache Line Fill Sequencer

This block refills one 32-byte cache line, made of eight 32-bit words, over a 64-bit memory data bus. Each bus beat carries two words, so a refill always takes exactly four beats. A requester hands over the line number and the index (0 to 7) of the word that missed. The block issues one burst address, which points at the double word holding the missed word. It then takes beats in wrap-around order, starting at that double word and ending with the one just before it.

The missed word goes back to the processor as soon as the first beat lands, so the pipeline can restart before the rest of the line arrives. Each beat is also written into a line buffer at its own position. After the fourth beat, the whole line is presented for one cycle together with a completion pulse. Only one refill is in flight at a time. The request side is held off from acceptance until the cycle after completion.

Top module: `cwf_line_fill`

## Requirements
- R1: After synchronous reset, req_ready is 1, bus_addr_valid, crit_valid and line_done are 0, and line_data is all zeros.
- R2: A request is accepted on a clock edge where req_valid and req_ready are both 1. In the next cycle, bus_addr_valid is 1 for exactly one cycle. bus_addr is {req_line, req_word[2:1], 3'b000}, a byte address of the starting double word.
- R3: req_ready is 0 from the cycle after acceptance through the line_done cycle, and is 1 again in the cycle after line_done. A request presented while req_ready is 0 is ignored and issues no bus address.
- R4: With start s = req_word[2:1], the k-th accepted beat (k = 0..3) is double word (s+k) mod 4. Within a beat, bits [31:0] hold word 2d and bits [63:32] hold word 2d+1. In line_data, word w sits at bits [32w+31:32w].
- R5: In the cycle after the first beat is accepted, crit_valid is 1 for exactly one cycle, and crit_data equals word req_word of the line. crit_valid is never 1 at any other time of a fill.
- R6: In the cycle after the fourth beat is accepted, line_done is 1 for exactly one cycle, and line_data holds the complete line.
- R7: beat_valid is ignored while no refill is in progress. It raises neither crit_valid nor line_done, and it leaves line_data unchanged.
- R8: A beat may arrive in the same cycle that bus_addr_valid is 1, and idle cycles between beats are allowed.
- R9: Reset in the middle of a refill discards the partial line. Afterwards line_data is zero, line_done does not fire, req_ready is 1, and the next refill completes normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Refill request present |
| req_ready | output | 1 | Block can accept a request |
| req_line | input | ADDR_W-5 (27) | Line number of the missed line |
| req_word | input | 3 | Index of the missed word in the line |
| bus_addr_valid | output | 1 | One-cycle burst address strobe |
| bus_addr | output | ADDR_W (32) | Byte address of the first double word of the burst |
| beat_valid | input | 1 | Data beat present on beat_data |
| beat_data | input | 64 | Double word from memory |
| crit_valid | output | 1 | Missed word is on crit_data |
| crit_data | output | 32 | Missed word |
| line_done | output | 1 | Line complete pulse |
| line_data | output | 256 | Assembled line |

## Verification
Two functions can land in the same cycle. The first is the address strobe and acceptance of the first beat, when the memory model answers with zero latency. The second is the line buffer write and the critical-word capture of that same beat. The bench provokes the first by driving beat_valid in the very cycle bus_addr_valid is seen. Refills then run with random latencies, random gaps between beats and every start word. Each case is judged by comparing crit_data, the single address strobe and the full line against values the bench computes from the line number and beat index.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_DONE = 2'd2
  } fill_state_e;
endpackage

// File: rtl/cwf_ctrl.sv
module cwf_ctrl #(
  parameter int ADDR_W     = 32,
  parameter int OFF_W      = 5,
  parameter int BEATS      = 4,
  parameter int WORD_IDX_W = 3,
  localparam int BIDX_W    = $clog2(BEATS),
  localparam int WSEL_W    = WORD_IDX_W - BIDX_W,
  localparam int BOFF_W    = OFF_W - BIDX_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ADDR_W-OFF_W-1:0] req_line,
  input  logic [WORD_IDX_W-1:0]   req_word,
  output logic                    bus_addr_valid,
  output logic [ADDR_W-1:0]       bus_addr,
  input  logic                    beat_valid,
  output logic                    beat_we,
  output logic [BIDX_W-1:0]       beat_pos,
  output logic                    beat_first,
  output logic [WSEL_W-1:0]       crit_sel,
  output logic                    line_done
);
  import cwf_pkg::*;

  fill_state_e       state_q;
  logic [BIDX_W-1:0] start_q;
  logic [BIDX_W-1:0] cnt_q;
  logic [WSEL_W-1:0] wsel_q;
  logic              accept;
  logic              beat_last;

  assign req_ready  = (state_q == ST_IDLE);
  assign accept     = req_ready && req_valid;
  assign beat_we    = (state_q == ST_FILL) && beat_valid;
  assign beat_pos   = start_q + cnt_q;
  assign beat_first = beat_we && (cnt_q == '0);
  assign beat_last  = beat_we && (cnt_q == BIDX_W'(BEATS - 1));
  assign crit_sel   = wsel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q        <= ST_IDLE;
      start_q        <= '0;
      cnt_q          <= '0;
      wsel_q         <= '0;
      bus_addr_valid <= 1'b0;
      bus_addr       <= '0;
      line_done      <= 1'b0;
    end else begin
      bus_addr_valid <= 1'b0;
      line_done      <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            start_q        <= req_word[WORD_IDX_W-1 -: BIDX_W];
            wsel_q         <= req_word[WSEL_W-1:0];
            cnt_q          <= '0;
            bus_addr_valid <= 1'b1;
            bus_addr       <= {req_line, req_word[WORD_IDX_W-1 -: BIDX_W], {BOFF_W{1'b0}}};
            state_q        <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (beat_we) begin
            cnt_q <= cnt_q + 1'b1;
            if (beat_last) begin
              line_done <= 1'b1;
              state_q   <= ST_DONE;
            end
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cwf_crit_pick.sv
module cwf_crit_pick #(
  parameter int WORD_W = 32,
  parameter int WPB    = 2,
  localparam int BEAT_W = WORD_W * WPB,
  localparam int WSEL_W = $clog2(WPB)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [WSEL_W-1:0] sel,
  input  logic [BEAT_W-1:0] beat_data,
  output logic              crit_valid,
  output logic [WORD_W-1:0] crit_data
);
  logic [WORD_W-1:0] words [WPB];

  for (genvar i = 0; i < WPB; i++) begin : g_split
    assign words[i] = beat_data[i*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      crit_valid <= 1'b0;
      crit_data  <= '0;
    end else begin
      crit_valid <= take;
      if (take) crit_data <= words[sel];
    end
  end
endmodule

// File: rtl/cwf_line_buf.sv
module cwf_line_buf #(
  parameter int BEAT_W = 64,
  parameter int BEATS  = 4,
  localparam int BIDX_W = $clog2(BEATS),
  localparam int LINE_W = BEAT_W * BEATS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [BIDX_W-1:0] pos,
  input  logic [BEAT_W-1:0] din,
  output logic [LINE_W-1:0] line_data
);
  for (genvar i = 0; i < BEATS; i++) begin : g_slot
    logic [BEAT_W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (rst)                             slot_q <= '0;
      else if (we && pos == BIDX_W'(i))    slot_q <= din;
    end
    assign line_data[i*BEAT_W +: BEAT_W] = slot_q;
  end
endmodule

// File: rtl/cwf_line_fill.sv
module cwf_line_fill #(
  parameter int ADDR_W      = 32,
  parameter int WORD_W      = 32,
  parameter int BEAT_W      = 64,
  parameter int LINE_WORDS  = 8,
  localparam int WPB        = BEAT_W / WORD_W,
  localparam int BEATS      = LINE_WORDS / WPB,
  localparam int WORD_IDX_W = $clog2(LINE_WORDS),
  localparam int WSEL_W     = $clog2(WPB),
  localparam int BIDX_W     = $clog2(BEATS),
  localparam int OFF_W      = $clog2(LINE_WORDS * WORD_W / 8),
  localparam int LINE_W     = WORD_W * LINE_WORDS
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ADDR_W-OFF_W-1:0] req_line,
  input  logic [WORD_IDX_W-1:0]   req_word,
  output logic                    bus_addr_valid,
  output logic [ADDR_W-1:0]       bus_addr,
  input  logic                    beat_valid,
  input  logic [BEAT_W-1:0]       beat_data,
  output logic                    crit_valid,
  output logic [WORD_W-1:0]       crit_data,
  output logic                    line_done,
  output logic [LINE_W-1:0]       line_data
);
  logic              beat_we;
  logic [BIDX_W-1:0] beat_pos;
  logic              beat_first;
  logic [WSEL_W-1:0] crit_sel;

  cwf_ctrl #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .BEATS(BEATS), .WORD_IDX_W(WORD_IDX_W)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_line(req_line), .req_word(req_word),
    .bus_addr_valid(bus_addr_valid), .bus_addr(bus_addr),
    .beat_valid(beat_valid), .beat_we(beat_we), .beat_pos(beat_pos),
    .beat_first(beat_first), .crit_sel(crit_sel), .line_done(line_done)
  );

  cwf_crit_pick #(.WORD_W(WORD_W), .WPB(WPB)) u_crit (
    .clk(clk), .rst(rst), .take(beat_first), .sel(crit_sel),
    .beat_data(beat_data), .crit_valid(crit_valid), .crit_data(crit_data)
  );

  cwf_line_buf #(.BEAT_W(BEAT_W), .BEATS(BEATS)) u_buf (
    .clk(clk), .rst(rst), .we(beat_we), .pos(beat_pos),
    .din(beat_data), .line_data(line_data)
  );
endmodule

// File: rtl/cwf_line_fill_chk.sv
module cwf_line_fill_chk #(
  parameter int ADDR_W     = 32,
  parameter int OFF_W      = 5,
  parameter int WORD_IDX_W = 3,
  parameter int BIDX_W     = 2
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    req_valid,
  input logic                    req_ready,
  input logic [ADDR_W-OFF_W-1:0] req_line,
  input logic [WORD_IDX_W-1:0]   req_word,
  input logic                    bus_addr_valid,
  input logic [ADDR_W-1:0]       bus_addr,
  input logic                    crit_valid,
  input logic                    line_done
);
  localparam int BOFF_W = OFF_W - BIDX_W;

  p_addr_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    bus_addr_valid |=> !bus_addr_valid);

  p_accept_issues_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> bus_addr_valid);

  p_addr_value_r2: assert property (@(posedge clk) disable iff (rst)
    bus_addr_valid |-> bus_addr == {$past(req_line), $past(req_word[WORD_IDX_W-1 -: BIDX_W]), {BOFF_W{1'b0}}});

  p_busy_on_issue_r3: assert property (@(posedge clk) disable iff (rst)
    bus_addr_valid |-> !req_ready);

  p_busy_on_done_r3: assert property (@(posedge clk) disable iff (rst)
    line_done |-> !req_ready);

  p_crit_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    crit_valid |=> !crit_valid);

  p_crit_not_done_r5: assert property (@(posedge clk) disable iff (rst)
    crit_valid |-> !line_done);

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    line_done |=> (!line_done && req_ready));
endmodule

bind cwf_line_fill cwf_line_fill_chk #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .WORD_IDX_W(WORD_IDX_W), .BIDX_W(BIDX_W)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_line(req_line), .req_word(req_word),
  .bus_addr_valid(bus_addr_valid), .bus_addr(bus_addr),
  .crit_valid(crit_valid), .line_done(line_done)
);

// File: tb/tb_cwf_line_fill.sv
module tb_cwf_line_fill;
  logic         clk = 1'b0;
  logic         rst;
  logic         req_valid;
  logic         req_ready;
  logic [26:0]  req_line;
  logic [2:0]   req_word;
  logic         bus_addr_valid;
  logic [31:0]  bus_addr;
  logic         beat_valid;
  logic [63:0]  beat_data;
  logic         crit_valid;
  logic [31:0]  crit_data;
  logic         line_done;
  logic [255:0] line_data;

  int total = 0;
  int bad   = 0;
  int addr_cnt = 0, crit_cnt = 0, done_cnt = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  cwf_line_fill dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_line(req_line), .req_word(req_word),
    .bus_addr_valid(bus_addr_valid), .bus_addr(bus_addr),
    .beat_valid(beat_valid), .beat_data(beat_data),
    .crit_valid(crit_valid), .crit_data(crit_data),
    .line_done(line_done), .line_data(line_data)
  );

  always @(negedge clk) begin
    if (bus_addr_valid) addr_cnt++;
    if (crit_valid)     crit_cnt++;
    if (line_done)      done_cnt++;
  end

  function automatic logic [63:0] mem_beat(logic [26:0] ln, int d);
    logic [31:0] lo, hi;
    lo = {5'd0, ln} * 32'h9E37 + 32'(d) * 32'h1111_0101;
    hi = lo ^ 32'hC0FF_EE00 ^ {28'd0, 4'(d)};
    return {hi, lo};
  endfunction

  function automatic logic [255:0] exp_line(logic [26:0] ln);
    logic [255:0] r;
    for (int d = 0; d < 4; d++) r[d*64 +: 64] = mem_beat(ln, d);
    return r;
  endfunction

  task automatic chk(bit ok, string tag, logic [255:0] act, logic [255:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_fill(logic [26:0] ln, logic [2:0] w, int lat, int gap, bit poke);
    int s, a0, c0, d0;
    logic [255:0] el;
    s  = int'(w[2:1]);
    el = exp_line(ln);
    while (!req_ready) @(negedge clk);
    #1;
    a0 = addr_cnt; c0 = crit_cnt; d0 = done_cnt;
    req_valid = 1'b1; req_line = ln; req_word = w;
    @(negedge clk);
    req_valid = 1'b0;
    chk(bus_addr_valid == 1'b1, "R2 addr strobe", 256'(bus_addr_valid), 256'd1);
    chk(bus_addr == {ln, w[2:1], 3'b000}, "R2 addr value", 256'(bus_addr), 256'({ln, w[2:1], 3'b000}));
    chk(req_ready == 1'b0, "R3 busy after accept", 256'(req_ready), 256'd0);
    if (lat > 0) repeat (lat) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      beat_valid = 1'b1;
      beat_data  = mem_beat(ln, (s + k) % 4);
      @(negedge clk);
      beat_valid = 1'b0;
      beat_data  = {$urandom, $urandom};
      if (k == 0) begin
        chk(crit_valid == 1'b1, "R5 crit strobe", 256'(crit_valid), 256'd1);
        chk(crit_data == el[32*w +: 32], "R5 crit word", 256'(crit_data), 256'(el[32*w +: 32]));
      end
      if (k < 3) begin
        for (int g = 0; g < gap; g++) begin
          if (poke) begin
            req_valid = 1'b1; req_line = 27'($urandom); req_word = 3'($urandom);
          end
          @(negedge clk);
        end
        req_valid = 1'b0;
        chk(line_done == 1'b0, "R6 no early done", 256'(line_done), 256'd0);
      end else begin
        chk(line_done == 1'b1, "R6 done strobe", 256'(line_done), 256'd1);
        chk(line_data == el, "R4 line content", line_data, el);
        chk(req_ready == 1'b0, "R3 busy at done", 256'(req_ready), 256'd0);
      end
    end
    @(negedge clk);
    #1;
    chk(req_ready == 1'b1 && line_done == 1'b0, "R3 ready after done", 256'({req_ready, line_done}), 256'b10);
    chk(addr_cnt - a0 == 1, "R3 single address per fill", 256'(addr_cnt - a0), 256'd1);
    chk(crit_cnt - c0 == 1, "R5 single crit per fill", 256'(crit_cnt - c0), 256'd1);
    chk(done_cnt - d0 == 1, "R6 single done per fill", 256'(done_cnt - d0), 256'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    logic [255:0] held;
    int c0, d0;
    seed = $urandom(32'h5EED_1234);
    rst = 1'b1; req_valid = 1'b0; req_line = '0; req_word = '0;
    beat_valid = 1'b0; beat_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready", 256'(req_ready), 256'd1);
    chk({bus_addr_valid, crit_valid, line_done} == 3'b000, "R1 strobes low",
        256'({bus_addr_valid, crit_valid, line_done}), 256'd0);
    chk(line_data == '0, "R1 line clear", line_data, 256'd0);

    // directed corners: first and last word, zero latency (R8), gaps
    do_fill(27'h1234567, 3'd0, 0, 0, 1'b0);
    do_fill(27'h0ABCDEF, 3'd7, 0, 2, 1'b1);
    do_fill(27'h7FFFFFF, 3'd3, 3, 1, 1'b1);
    do_fill(27'h0000001, 3'd4, 0, 0, 1'b0);

    // R7: beats while idle are ignored
    held = line_data;
    #1; c0 = crit_cnt; d0 = done_cnt;
    beat_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      beat_data = {$urandom, $urandom};
      @(negedge clk);
    end
    beat_valid = 1'b0;
    @(negedge clk); #1;
    chk(crit_cnt == c0 && done_cnt == d0, "R7 no strobes from idle beats",
        256'(crit_cnt - c0 + done_cnt - d0), 256'd0);
    chk(line_data == held, "R7 line unchanged", line_data, held);
    chk(req_ready == 1'b1, "R7 still idle", 256'(req_ready), 256'd1);

    // R9: reset in mid-fill
    #1; d0 = done_cnt;
    req_valid = 1'b1; req_line = 27'h0555555; req_word = 3'd5;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 2; k++) begin
      beat_valid = 1'b1; beat_data = mem_beat(27'h0555555, (2 + k) % 4);
      @(negedge clk);
    end
    beat_valid = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    chk(line_data == '0, "R9 partial line discarded", line_data, 256'd0);
    chk(req_ready == 1'b1, "R9 ready after reset", 256'(req_ready), 256'd1);
    chk(done_cnt == d0, "R9 no done after reset", 256'(done_cnt - d0), 256'd0);
    do_fill(27'h0555555, 3'd5, 1, 0, 1'b0);

    // random mix
    for (int n = 0; n < 40; n++)
      do_fill(27'($urandom), 3'($urandom % 8), int'($urandom % 4), int'($urandom % 3), 1'($urandom));

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule